// File: doc/BRIEF.md
# Serial EEPROM Write-Busy Interface

This block models the device side of a small clocked serial EEPROM inside a larger design. A controller selects it with `sel` and shifts frames in on `sdi`, one bit per rising edge of `sclk`. The core clock `clk` samples all pins, and `sclk` must be slow enough that each level lasts at least one `clk` cycle. A frame starts with an 8-bit command. For reads and writes, a word address follows, and for writes a data word follows that, most significant bit first. A word is only written if an enable command has been accepted earlier.

A write does not reach the array at once. A counter stands in for the programming time. While it runs, the dedicated `rdy` pin is low. When the device is deselected, busy is also visible on `sdo`. After a write completes, `sdo` holds a ready level of 1 until the controller raises `sdi`. An `abort` pulse ends a running write at once and leaves the target word marked as damaged (all ones). Data out is modelled as a value `sdo` plus an enable `sdo_oe` instead of a tri-state net.

The controller is one state machine:
- States: `ST_IDLE`, `ST_OPC`, `ST_ADDR`, `ST_DATA`, `ST_RDOUT`, `ST_BUSY`, `ST_SKIP`.
- Shifting transitions: `ST_IDLE`→`ST_OPC` on select. `ST_OPC`→`ST_ADDR` after a read command, or after a write command while enabled. `ST_OPC`→`ST_SKIP` after the enable command, an unknown command, or a write command while not enabled. `ST_ADDR`→`ST_DATA` for a write. `ST_ADDR`→`ST_RDOUT` for a read. `ST_DATA`→`ST_BUSY` on the last data bit.
- Return transitions: `ST_BUSY`→`ST_IDLE` when the timer expires. Every shifting state, `ST_RDOUT` and `ST_SKIP` go to `ST_IDLE` on deselect.
- Abort: an `abort` pulse sends any state to `ST_SKIP`.

Top module: `sereep_wbusy`

## Requirements
- R1: A write frame is the command, then 8 address bits, then 16 data bits, each field MSB first, 32 `sclk` rises in all. A later read of that address returns the word. The array clears to zero on `rst_n`.
- R2: The command codes, sent leftmost bit first, are:
  - enable `10100011`: sets a write-enable latch that stays set until `rst_n`.
  - write `10100100`.
  - read `10100110`.
  - Any other code is ignored: `rdy` stays 1, `sdo_oe` stays 0 while selected, and no word changes.
- R3: `rdy` falls in the first `clk` cycle after the 32nd `sclk` rise is sampled. It stays 0 for exactly WR_CYCLES+1 cycles, then returns to 1.
- R4: `rdy` does not depend on `sel`. Changing `sel` during busy leaves `rdy` at 0.
- R5: During busy, `sel`=0 gives `sdo_oe`=1 and `sdo`=0. During busy, `sel`=1 gives `sdo_oe`=0.
- R6: After a write completes, `sel`=0 gives `sdo_oe`=1 and `sdo`=1. The first 0→1 change of `sdi` returns `sdo_oe` to 0.
- R7: An `abort` pulse during busy sets `rdy` to 1 in the next cycle. It sets the ready level of R6, and it writes all ones to the target word.
- R8: An `abort` pulse during a write frame, before busy, prevents the write. `rdy` stays 1 and the word keeps its old value.
- R9: An `abort` pulse after busy has ended leaves the newly written word in place.
- R10: A write frame sent while the enable latch is clear is ignored. `rdy` stays 1 and the word is unchanged.
- R11: After the 16th `sclk` rise of a read frame, `sdo_oe`=1 while selected and `sdo` shows data bit 15. Each further rise moves to the next lower bit.
- R12: Deselecting before the 32nd rise abandons the frame. No busy period follows and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Device select, high while a frame is shifted |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data in |
| abort | input | 1 | Active-high pulse that cancels a frame or a running write |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| rdy | output | 1 | Ready (1) / busy (0), independent of `sel` |

## Verification
The hardest situation to reach from the ports is an abort that lands inside the short busy window. The stimulus ends the frame, deselects, and pulses `abort` a few cycles later, well before the timer can expire. The damage is then read back through a normal read frame. Two neighbouring cases bracket it:
- an abort before the last data bit, which must leave the old word;
- an abort after `rdy` has returned, which must leave the new word.

The exact busy length is checked by counting `clk` cycles at the ports during a write. Inside that window the bench toggles `sel` to exercise both `sdo` paths.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_WREN  = 8'b1010_0011;
    localparam logic [OPC_W-1:0] OP_WRITE = 8'b1010_0100;
    localparam logic [OPC_W-1:0] OP_READ  = 8'b1010_0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_RDOUT,
        ST_BUSY,
        ST_SKIP
    } ee_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRITE,
        CMD_READ
    } ee_cmd_t;

    function automatic ee_cmd_t decode_op(input logic [OPC_W-1:0] op);
        ee_cmd_t c;
        case (op)
            OP_WREN:  c = CMD_WREN;
            OP_WRITE: c = CMD_WRITE;
            OP_READ:  c = CMD_READ;
            default:  c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ee_pin_sampler.sv
module ee_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    output logic sclk_rise,
    output logic sdi_rise
);
    logic sclk_q;
    logic sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sdi_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sdi_q  <= sdi;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sdi_rise  = sdi & ~sdi_q;
endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
    parameter int CYCLES = 24,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(CYCLES);
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ee_word_array.sv
module ee_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (we && waddr == ADDR_W'(g)) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sereep_wbusy.sv
module sereep_wbusy
    import ee_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    input  logic abort,
    output logic sdo,
    output logic sdo_oe,
    output logic rdy
);
    localparam int PH_W  = $clog2(DATA_W + 1);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    ee_state_t         state, state_nxt;
    ee_cmd_t           cmd, op_cmd;
    logic [PH_W-1:0]   bit_cnt;
    logic [DATA_W-1:0] in_sr, word_in, rd_sr, data_q, arr_rdata, arr_wdata;
    logic [ADDR_W-1:0] addr_q, addr_in;
    logic              wen_q, ready_q;
    logic              sclk_rise, sdi_rise;
    logic              shifting, last_opc, last_addr, last_data;
    logic              start_busy, tmr_done, arr_we;

    ee_pin_sampler u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sdi_rise  (sdi_rise)
    );

    ee_busy_timer #(.CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_busy),
        .run   (state == ST_BUSY),
        .done  (tmr_done)
    );

    ee_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (addr_q),
        .wdata (arr_wdata),
        .raddr (addr_in),
        .rdata (arr_rdata)
    );

    // Frame decode helpers
    assign word_in   = {in_sr[DATA_W-2:0], sdi};
    assign addr_in   = word_in[ADDR_W-1:0];
    assign op_cmd    = decode_op(word_in[OPC_W-1:0]);
    assign shifting  = (state == ST_OPC) || (state == ST_ADDR) || (state == ST_DATA);
    assign last_opc  = sclk_rise && (bit_cnt == PH_W'(OPC_W - 1));
    assign last_addr = sclk_rise && (bit_cnt == PH_W'(ADDR_W - 1));
    assign last_data = sclk_rise && (bit_cnt == PH_W'(DATA_W - 1));

    assign start_busy = (state_nxt == ST_BUSY) && (state != ST_BUSY);
    assign arr_we     = (state == ST_BUSY) && (abort || tmr_done);
    assign arr_wdata  = abort ? '1 : data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sel) state_nxt = ST_OPC;
            end
            ST_OPC: begin
                if (!sel) begin
                    state_nxt = ST_IDLE;
                end else if (last_opc) begin
                    case (op_cmd)
                        CMD_WRITE: state_nxt = wen_q ? ST_ADDR : ST_SKIP;
                        CMD_READ:  state_nxt = ST_ADDR;
                        default:   state_nxt = ST_SKIP;
                    endcase
                end
            end
            ST_ADDR: begin
                if (!sel) begin
                    state_nxt = ST_IDLE;
                end else if (last_addr) begin
                    state_nxt = (cmd == CMD_WRITE) ? ST_DATA : ST_RDOUT;
                end
            end
            ST_DATA: begin
                if (!sel) begin
                    state_nxt = ST_IDLE;
                end else if (last_data) begin
                    state_nxt = ST_BUSY;
                end
            end
            ST_RDOUT, ST_SKIP: begin
                if (!sel) state_nxt = ST_IDLE;
            end
            ST_BUSY: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (abort) state_nxt = ST_SKIP;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sr   <= '0;
            cmd     <= CMD_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            rd_sr   <= '0;
            wen_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            if (state_nxt != state) begin
                bit_cnt <= '0;
            end else if (shifting && sclk_rise) begin
                bit_cnt <= bit_cnt + PH_W'(1);
            end
            if (shifting && sclk_rise) in_sr <= word_in;
            if (state == ST_OPC && last_opc) begin
                cmd <= op_cmd;
                if (op_cmd == CMD_WREN && sel && !abort) wen_q <= 1'b1;
            end
            if (state == ST_ADDR && last_addr) begin
                addr_q <= addr_in;
                rd_sr  <= arr_rdata;
            end else if (state == ST_RDOUT && sclk_rise) begin
                rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
            end
            if (state == ST_DATA && last_data) data_q <= word_in;
            if (arr_we) begin
                ready_q <= 1'b1;
            end else if (sdi_rise || start_busy) begin
                ready_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        rdy    = (state != ST_BUSY);
        sdo    = 1'b0;
        sdo_oe = 1'b0;
        unique case (state)
            ST_BUSY: begin
                sdo_oe = !sel;
                sdo    = 1'b0;
            end
            ST_RDOUT: begin
                sdo_oe = sel;
                sdo    = rd_sr[DATA_W-1];
            end
            default: begin
                if (!sel && ready_q) begin
                    sdo_oe = 1'b1;
                    sdo    = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/ee_checker.sv
module ee_checker #(
    parameter int WR_CYCLES = 24
) (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic abort,
    input logic sdo,
    input logic sdo_oe,
    input logic rdy
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (!rdy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WR_CYCLES + 1);

    assert_busy_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(sel));

    assert_busy_on_sdo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !sel) |-> (sdo_oe && !sdo));

    assert_busy_sel_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && sel) |-> !sdo_oe);

    assert_ready_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && sdo_oe && rdy) |-> sdo);

    assert_abort_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> rdy);
endmodule

bind sereep_wbusy ee_checker #(.WR_CYCLES(WR_CYCLES)) u_ee_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .abort  (abort),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .rdy    (rdy)
);

// File: tb/test_sereep_wbusy.sv
module test_sereep_wbusy;
    localparam int WRC = 24;
    localparam logic [7:0] C_WREN  = 8'b1010_0011;
    localparam logic [7:0] C_WRITE = 8'b1010_0100;
    localparam logic [7:0] C_READ  = 8'b1010_0110;
    localparam logic [7:0] C_BAD   = 8'b1010_0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, abort = 1'b0;
    logic sdo, sdo_oe, rdy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sereep_wbusy #(.ADDR_W(8), .DATA_W(16), .WR_CYCLES(WRC)) i_sereep_wbusy (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .abort(abort), .sdo(sdo), .sdo_oe(sdo_oe), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame_begin();
        @(negedge clk); sel = 1'b1; sclk = 1'b0; sdi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_end();
        @(negedge clk); sclk = 1'b0; sdi = 1'b0; sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sdi = v[i]; sclk = 1'b0;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic send_wren();
        frame_begin(); send_bits(16'(C_WREN), 8); frame_end();
    endtask

    // Full write with busy-window checks
    task automatic write_checked(input logic [7:0] a, input logic [15:0] d);
        int n;
        frame_begin();
        send_bits(16'(C_WRITE), 8);
        send_bits(16'(a), 8);
        send_bits(d >> 1, 15);
        @(negedge clk); sdi = d[0]; sclk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 ready before last rise", 32'(rdy), 32'd1);
        sclk = 1'b1;
        @(negedge clk); n = 1;
        chk("R3 busy after last rise", 32'(rdy), 32'd0);
        sclk = 1'b0; sdi = 1'b0; sel = 1'b0;
        @(negedge clk); n++;
        chk("R5 busy on sdo oe", 32'(sdo_oe), 32'd1);
        chk("R5 busy on sdo val", 32'(sdo), 32'd0);
        sel = 1'b1;
        @(negedge clk); n++;
        chk("R5 sel high hiz", 32'(sdo_oe), 32'd0);
        chk("R4 rdy ignores sel", 32'(rdy), 32'd0);
        sel = 1'b0;
        @(negedge clk);
        while (!rdy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R3 busy length", 32'(n), 32'(WRC + 1));
        chk("R6 ready level oe", 32'(sdo_oe), 32'd1);
        chk("R6 ready level val", 32'(sdo), 32'd1);
        sdi = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 sdi rise releases sdo", 32'(sdo_oe), 32'd0);
        sdi = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_word(input logic [7:0] a, output logic [15:0] d);
        logic oe_ok;
        oe_ok = 1'b1;
        d = '0;
        frame_begin();
        send_bits(16'(C_READ), 8);
        send_bits(16'(a), 8);
        for (int i = 0; i < 16; i++) begin
            if (!sdo_oe) oe_ok = 1'b0;
            d = {d[14:0], sdo};
            if (i < 15) send_bits(16'd0, 1);
        end
        chk("R11 read drives sdo", 32'(oe_ok), 32'd1);
        frame_end();
    endtask

    function automatic logic [15:0] pat(input logic [7:0] a);
        return (16'(a) * 16'h0101) ^ 16'hA5C3;
    endfunction

    task automatic watch_rdy_high(input string req, input int cycles);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!rdy) ok = 1'b0;
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        chk("R1 reset rdy", 32'(rdy), 32'd1);
        chk("R1 reset sdo_oe", 32'(sdo_oe), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        read_word(8'h00, rd);
        chk("R1 array cleared", 32'(rd), 32'h0);

        // R10: write without enable
        frame_begin();
        send_bits(16'(C_WRITE), 8); send_bits(16'h42, 8); send_bits(16'h1234, 16);
        frame_end();
        watch_rdy_high("R10 no busy without enable", WRC + 8);
        read_word(8'h42, rd);
        chk("R10 word unchanged", 32'(rd), 32'h0);

        // R2: unknown command ignored
        frame_begin();
        send_bits(16'(C_BAD), 8); send_bits(16'h42, 8);
        chk("R2 unknown cmd no sdo", 32'(sdo_oe), 32'd0);
        send_bits(16'hBEEF, 16);
        frame_end();
        watch_rdy_high("R2 unknown cmd no busy", WRC + 8);

        send_wren();

        // R1/R11 sweep
        for (int k = 0; k < 32; k++) write_checked(8'(k * 8 + 3), pat(8'(k * 8 + 3)));
        for (int k = 0; k < 32; k++) begin
            read_word(8'(k * 8 + 3), rd);
            chk("R1 R11 readback", 32'(rd), 32'(pat(8'(k * 8 + 3))));
        end
        read_word(8'h04, rd);
        chk("R1 neighbour untouched", 32'(rd), 32'h0);

        // R2: unknown code after enable leaves word alone
        frame_begin();
        send_bits(16'(C_BAD), 8); send_bits(16'd3, 8); send_bits(16'h0F0F, 16);
        frame_end();
        watch_rdy_high("R2 unknown cmd no busy after enable", WRC + 8);
        read_word(8'd3, rd);
        chk("R2 word kept", 32'(rd), 32'(pat(8'd3)));

        // R12: deselect mid-frame
        frame_begin();
        send_bits(16'(C_WRITE), 8); send_bits(16'd11, 8); send_bits(16'h0FF, 12);
        frame_end();
        watch_rdy_high("R12 abandoned frame no busy", WRC + 8);
        read_word(8'd11, rd);
        chk("R12 word unchanged", 32'(rd), 32'(pat(8'd11)));

        // R8: abort during frame
        frame_begin();
        send_bits(16'(C_WRITE), 8); send_bits(16'd19, 8); send_bits(16'h12, 8);
        pulse_abort();
        send_bits(16'h34, 8);
        frame_end();
        watch_rdy_high("R8 abort before busy", WRC + 8);
        read_word(8'd19, rd);
        chk("R8 word unchanged", 32'(rd), 32'(pat(8'd19)));

        // R7: abort during busy
        frame_begin();
        send_bits(16'(C_WRITE), 8); send_bits(16'd27, 8); send_bits(16'h1357, 16);
        frame_end();
        chk("R7 busy before abort", 32'(rdy), 32'd0);
        pulse_abort();
        chk("R7 ready after abort", 32'(rdy), 32'd1);
        chk("R7 ready level on sdo", 32'({sdo_oe, sdo}), 32'd3);
        read_word(8'd27, rd);
        chk("R7 word corrupted", 32'(rd), 32'hFFFF);

        // R9: abort after completion
        write_checked(8'd35, 16'h2468);
        pulse_abort();
        read_word(8'd35, rd);
        chk("R9 word kept after late abort", 32'(rd), 32'h2468);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule